// File: doc/BRIEF.md
# Six-Channel Lead-In Pulse Generator

This block drives six independent pulse outputs. Each channel's waveform is set by two cycle counts: the number of clock cycles the output stays high, followed by the number of cycles it stays low. Together these form one period. When software enables a channel, the output first stays low for a programmable lead-in interval, and only then does the periodic waveform begin. A channel can run forever, or it can stop by itself after a programmed number of periods. When it stops by itself it clears its own enable bit.

Software reaches the channels through a plain 32-bit word-wide read/write port. New timing values written while a channel runs are held back until the current period is over, so the waveform never shows a torn period. Clearing the enable bit cuts the output straight away, even in the middle of a period. Read data is registered and appears one cycle after the read strobe.

Top module: `lpwm_top`

## Requirements
- R1: After reset, and after any later reset, every output is low and every register reads 0.
- R2: A channel c (0..5) has a control word at byte address 4*c and a timing word at 0x20+4*c. The control word holds enable in bit 31, the lead-in count in bits 30:16 and the repeat count in bits 15:0. The timing word holds the high count in bits 31:16 and the low count in bits 15:0. A written value reads back unchanged, and read data appears on the edge after the read strobe.
- R3: Reads from an address that is unaligned, or that lies at 0x18..0x1F or 0x38..0x3F, return 0. Writes to such an address change no register and no output.
- R4: If the enable write lands on clock edge E and the lead-in count is L, the output stays low until edge E+1+L. It then goes high if the high count is nonzero.
- R5: Each period drives the output high for H cycles and then low for W cycles, in that order, with no gap between periods.
- R6: With H=0 the output stays low. With W=0 it stays high. With both counts 0 it stays low, and each cycle counts as one period.
- R7: A timing word written while the channel runs leaves the current period unchanged and applies from the next period onward.
- R8: With a repeat count N>0, the channel produces exactly N periods. It then holds its output low and reads back with enable cleared and the other fields unchanged.
- R9: With a repeat count of 0, the waveform repeats with no end.
- R10: Once the enable bit has been cleared by a write, the output is low from the next clock edge, even partway through a period. A later enable restarts the channel with its lead-in and a fresh period count.
- R11: Each channel's output depends only on its own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one full 32-bit word |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_o | output | 6 | One registered pulse output per channel |

## Verification
The assertions assume that software does not rewrite a running channel's control word except to clear its enable bit. They also assume that read and write strobes carry word-wide data and are never given at the same time. The bench keeps to these assumptions by writing the full control word only when the channel is idle or when it clears the enable bit. It drives the two strobes from separate tasks that never overlap. Randomised counts are kept small so that every period, lead-in and repeat boundary falls inside the observation window.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
  localparam int CNT_W  = 16;
  localparam int LEAD_W = 15;

  typedef enum logic [1:0] {
    CH_IDLE,
    CH_LEAD,
    CH_HIGH,
    CH_LOW
  } ch_state_e;

  typedef struct packed {
    logic              en;
    logic [LEAD_W-1:0] lead;
    logic [CNT_W-1:0]  reps;
  } ctrl_word_t;

  typedef struct packed {
    logic [CNT_W-1:0] high;
    logic [CNT_W-1:0] low;
  } tim_word_t;
endpackage

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [NUM_CH-1:0]       done_i,
  output ctrl_word_t [NUM_CH-1:0] ctrl_o,
  output tim_word_t  [NUM_CH-1:0] tim_o
);
  localparam int SLOT_W = ADDR_W - 3;

  logic              aligned;
  logic              bank_tim;
  logic [SLOT_W-1:0] slot;
  logic              hit;
  logic [NUM_CH-1:0] ctrl_wr;
  logic [NUM_CH-1:0] tim_wr;
  logic [31:0]       rd_mux;

  ctrl_word_t [NUM_CH-1:0] ctrl_q;
  tim_word_t  [NUM_CH-1:0] tim_q;

  assign aligned  = (addr[1:0] == 2'b00);
  assign bank_tim = addr[ADDR_W-1];
  assign slot     = addr[ADDR_W-2:2];
  assign hit      = aligned && (int'(slot) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    assign ctrl_wr[c] = wr_en && hit && !bank_tim && (int'(slot) == c);
    assign tim_wr[c]  = wr_en && hit &&  bank_tim && (int'(slot) == c);

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[c] <= '0;
      end else if (ctrl_wr[c]) begin
        ctrl_q[c] <= ctrl_word_t'(wdata);
      end else if (done_i[c]) begin
        ctrl_q[c].en <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tim_q[c] <= '0;
      end else if (tim_wr[c]) begin
        tim_q[c] <= tim_word_t'(wdata);
      end
    end

    // a channel that finished on its own must read back disabled
    assert_done_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (done_i[c] && !ctrl_wr[c]) |=> !ctrl_q[c].en);
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit && (int'(slot) == c)) begin
        rd_mux = bank_tim ? 32'(tim_q[c]) : 32'(ctrl_q[c]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

  assign ctrl_o = ctrl_q;
  assign tim_o  = tim_q;

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> (rdata == 32'd0));
endmodule

// File: rtl/lpwm_chan.sv
module lpwm_chan
  import lpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctrl_word_t ctrl_i,
  input  tim_word_t  tim_i,
  output logic       pwm_o,
  output logic       done_o
);
  ch_state_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] act_high, ah_n;
  logic [CNT_W-1:0] act_low, al_n;
  logic [CNT_W-1:0] act_rep, rep_n;
  logic [CNT_W-1:0] per_num, pn_n;
  logic             out_q, out_n;
  logic             en;
  logic             per_end;
  logic             last;
  logic             start;
  ch_state_e        ps_st;
  logic [CNT_W-1:0] ps_cnt;
  logic             ps_out;

  assign en = ctrl_i.en;

  // first state of a period, taken from the live timing word
  always_comb begin
    if (tim_i.high != '0) begin
      ps_st  = CH_HIGH;
      ps_cnt = tim_i.high - CNT_W'(1);
      ps_out = 1'b1;
    end else begin
      ps_st  = CH_LOW;
      ps_cnt = (tim_i.low != '0) ? tim_i.low - CNT_W'(1) : '0;
      ps_out = 1'b0;
    end
  end

  assign per_end = (cnt == '0) &&
                   ((st == CH_LOW) || ((st == CH_HIGH) && (act_low == '0)));
  assign last    = per_end && (act_rep != '0) && (per_num == act_rep - CNT_W'(1));
  assign done_o  = en && last;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    out_n = out_q;
    ah_n  = act_high;
    al_n  = act_low;
    rep_n = act_rep;
    pn_n  = per_num;
    start = 1'b0;
    if (!en) begin
      st_n  = CH_IDLE;
      out_n = 1'b0;
    end else begin
      unique case (st)
        CH_IDLE: begin
          pn_n  = '0;
          rep_n = ctrl_i.reps;
          if (ctrl_i.lead != '0) begin
            st_n  = CH_LEAD;
            cnt_n = CNT_W'(ctrl_i.lead) - CNT_W'(1);
            out_n = 1'b0;
          end else begin
            start = 1'b1;
          end
        end
        CH_LEAD: begin
          if (cnt != '0) cnt_n = cnt - CNT_W'(1);
          else           start = 1'b1;
        end
        CH_HIGH: begin
          if (cnt != '0) begin
            cnt_n = cnt - CNT_W'(1);
          end else if (act_low != '0) begin
            st_n  = CH_LOW;
            cnt_n = act_low - CNT_W'(1);
            out_n = 1'b0;
          end
        end
        CH_LOW: begin
          if (cnt != '0) cnt_n = cnt - CNT_W'(1);
        end
      endcase
      if (per_end) begin
        pn_n = per_num + CNT_W'(1);
        if (last) begin
          st_n  = CH_IDLE;
          out_n = 1'b0;
        end else begin
          start = 1'b1;
        end
      end
      if (start) begin
        st_n  = ps_st;
        cnt_n = ps_cnt;
        out_n = ps_out;
        ah_n  = tim_i.high;
        al_n  = tim_i.low;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CH_IDLE;
      cnt      <= '0;
      out_q    <= 1'b0;
      act_high <= '0;
      act_low  <= '0;
      act_rep  <= '0;
      per_num  <= '0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      out_q    <= out_n;
      act_high <= ah_n;
      act_low  <= al_n;
      act_rep  <= rep_n;
      per_num  <= pn_n;
    end
  end

  assign pwm_o = out_q;

  assert_off_low_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_o);
  assert_rise_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> $past(en));
  assert_rep_bound_R8: assert property (@(posedge clk) disable iff (rst)
    ((act_rep != '0) && (st == CH_HIGH || st == CH_LOW)) |-> (per_num < act_rep));
  assert_high_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (st == CH_HIGH) |-> (cnt < act_high));
  assert_low_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (st == CH_LOW) |-> ((cnt < act_low) || (cnt == '0)));
endmodule

// File: rtl/lpwm_top.sv
module lpwm_top
  import lpwm_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_o
);
  ctrl_word_t [NUM_CH-1:0] ctrl_w;
  tim_word_t  [NUM_CH-1:0] tim_w;
  logic       [NUM_CH-1:0] done_w;

  lpwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .done_i (done_w),
    .ctrl_o (ctrl_w),
    .tim_o  (tim_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lpwm_chan u_ch (
      .clk    (clk),
      .rst    (rst),
      .ctrl_i (ctrl_w[c]),
      .tim_i  (tim_w[c]),
      .pwm_o  (pwm_o[c]),
      .done_o (done_w[c])
    );
  end
endmodule

// File: tb/lpwm_top_tb.sv
`timescale 1ns/1ps
module lpwm_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [5:0]  pwm_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  lpwm_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o)
  );

  function automatic bit model(int t, int l, int h, int w, int n);
    int p;
    int u;
    p = (h + w == 0) ? 1 : h + w;
    if (t < l) return 1'b0;
    u = t - l;
    if (n != 0 && (u / p) >= n) return 1'b0;
    return (u % p) < h;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cw(bit e, int l, int n);
    return {e, 15'(l), 16'(n)};
  endfunction

  function automatic logic [31:0] tw(int h, int w);
    return {16'(h), 16'(w)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(32'h5EED1234);
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 outputs", 32'(pwm_o), 32'd0);
    for (int a = 0; a < 12; a++) begin
      rd(6'((a < 6) ? 4*a : 32 + 4*(a-6)), d);
      chk("R1 register", d, 32'd0);
    end

    // R3 unmapped and unaligned accesses
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h38, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h01, 32'hFFFF_FFFF);
    wr(6'h22, 32'hFFFF_FFFF);
    rd(6'h18, d); chk("R3 read 0x18", d, 0);
    rd(6'h3C, d); chk("R3 read 0x3C", d, 0);
    rd(6'h01, d); chk("R3 read unaligned", d, 0);
    rd(6'h00, d); chk("R3 ctrl0 untouched", d, 0);
    rd(6'h20, d); chk("R3 tim0 untouched", d, 0);
    chk("R3 outputs", 32'(pwm_o), 0);

    // R2 map and readback
    for (int c = 0; c < 6; c++) begin
      wr(6'(4*c), cw(0, 100 + c, 7 * c + 3));
      wr(6'(32 + 4*c), tw(1000 + c, 2000 + 3*c));
    end
    for (int c = 0; c < 6; c++) begin
      rd(6'(4*c), d);      chk("R2 ctrl readback", d, cw(0, 100 + c, 7*c + 3));
      rd(6'(32 + 4*c), d); chk("R2 timing readback", d, tw(1000 + c, 2000 + 3*c));
    end
    chk("R2 outputs idle", 32'(pwm_o), 0);

    // R4 lead-in, R9 endless repetition
    wr(6'h24, tw(2, 3));
    wr(6'h04, cw(1, 5, 0));
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      chk(t < 6 ? "R4 lead-in" : "R9 endless", 32'(pwm_o[1]), 32'(model(t, 5, 2, 3, 0)));
    end
    wr(6'h04, 0);
    @(negedge clk);

    // R7 deferred timing update
    wr(6'h20, tw(4, 4));
    wr(6'h00, cw(1, 0, 0));
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R7 deferred update", 32'(pwm_o[0]),
          32'(t < 8 ? model(t, 0, 4, 4, 0) : model(t - 8, 0, 2, 1, 0)));
      if (t == 2) begin
        bus_wr = 1'b1; bus_addr = 6'h20; bus_wdata = tw(2, 1);
      end
    end
    wr(6'h00, 0);
    @(negedge clk);

    // R10 stop mid-period and restart
    wr(6'h28, tw(3, 3));
    wr(6'h08, cw(1, 0, 0));
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R10 stop", 32'(pwm_o[2]), 32'(t < 3 ? model(t, 0, 3, 3, 0) : 1'b0));
      if (t == 1) begin
        bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 0;
      end
    end
    rd(6'h08, d); chk("R10 reads disabled", d, 0);
    wr(6'h08, cw(1, 2, 2));
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      chk("R10 restart", 32'(pwm_o[2]), 32'(model(t, 2, 3, 3, 2)));
    end
    rd(6'h08, d); chk("R8 self-clear", d, cw(0, 2, 2));

    // R6 degenerate counts with repeat
    wr(6'h2C, tw(0, 0));
    wr(6'h0C, cw(1, 0, 4));
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      chk("R6 both zero", 32'(pwm_o[3]), 0);
    end
    rd(6'h0C, d); chk("R6 both zero periods counted", d, cw(0, 0, 4));

    // R11 two channels at once
    wr(6'h30, tw(3, 2));
    wr(6'h34, tw(1, 4));
    wr(6'h10, cw(1, 1, 0));
    wr(6'h14, cw(1, 3, 3));
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      chk("R11 ch4", 32'(pwm_o[4]), 32'(model(t + 1, 1, 3, 2, 0)));
      chk("R11 ch5", 32'(pwm_o[5]), 32'(model(t, 3, 1, 4, 3)));
      chk("R11 quiet", 32'(pwm_o[3:0]), 0);
    end
    wr(6'h10, 0);
    wr(6'h14, 0);
    @(negedge clk);

    // random mix: R5, R6, R8, R9, R11
    for (int it = 0; it < 40; it++) begin
      int ch, l, h, w, n, p, tmax;
      string tag;
      ch = $urandom_range(5, 0);
      l  = $urandom_range(5, 0);
      h  = $urandom_range(6, 0);
      w  = $urandom_range(6, 0);
      n  = $urandom_range(3, 0);
      p  = (h + w == 0) ? 1 : h + w;
      tmax = l + ((n != 0) ? n : 3) * p + 4;
      if (h == 0 || w == 0) tag = "R6 random";
      else if (n != 0)      tag = "R8 random";
      else                  tag = "R5 random";
      wr(6'(32 + 4*ch), tw(h, w));
      wr(6'(4*ch), cw(1, l, n));
      for (int t = 0; t < tmax; t++) begin
        @(negedge clk);
        chk(tag, 32'(pwm_o[ch]), 32'(model(t, l, h, w, n)));
        chk("R11 random others", 32'(pwm_o & ~(6'd1 << ch)), 0);
      end
      if (n != 0) begin
        rd(6'(4*ch), d);
        chk("R8 random readback", d, cw(0, l, n));
      end else begin
        wr(6'(4*ch), cw(0, l, n));
        @(negedge clk);
        chk("R10 random disable", 32'(pwm_o[ch]), 0);
      end
    end

    // R1 reset while running
    wr(6'h20, tw(1, 1));
    wr(6'h00, cw(1, 0, 0));
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset outputs", 32'(pwm_o), 0);
    rd(6'h00, d); chk("R1 reset ctrl", d, 0);
    rd(6'h20, d); chk("R1 reset timing", d, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule